// File: doc/BRIEF.md
# Compare-Overflow Timer Core

This block is a general-purpose up-counting timer. It has a register-controlled mode word, an optional power-of-two prescaler and autoreload on wrap. A compare register can raise a match event. A trigger pin can toggle or emit a single-cycle pulse when the timer overflows, or on both overflow and match.

Events land in a small status register. Each status bit is written only when its interrupt-enable bit is set, and software clears a bit by writing 1 to it. The interrupt line is high while any status bit is set. A second, independent enable mask turns the same events into a one-cycle wakeup pulse.

Software reaches every register through a flat port. The port has a write strobe, a 3-bit word address and write data, with combinational read data. Counting is paced by a functional clock-enable input.

Register words by address:
- 0: control word
- 1: status
- 2: interrupt enables
- 3: wakeup enables
- 4: live count
- 5: reload value
- 6: retrigger (reads all ones)
- 7: compare value

Control word bits:
- bit 0: run
- bit 1: autoreload
- bits 4:2: prescale exponent
- bit 5: prescale on
- bit 6: compare on
- bit 7: idle pin level
- bits 9:8: stored, no effect
- bits 11:10: trigger mode
- bit 12: toggle (1) or pulse (0)
- bit 13: stored, no effect
- bit 14: pin is input (1) or output (0)

Top module: `gp_timer_core`

## Requirements
- R1: After reset every register reads zero, and the retrigger word reads all ones. `irq`, `wake` and `pin_out` are low, and `pin_oe` is high.
- R2: With run=1 and prescale off, the count rises by one on every clock edge where `tick_en` is high. It does not change when `tick_en` is low or run is 0.
- R3: With prescale on (bit 5) and exponent p (bits 4:2), the count advances once per 2^(p+1) ticks.
- R4: From all ones with autoreload set (bit 1), the next advance loads the reload value (address 5), and run stays set.
- R5: From all ones without autoreload, the next advance clears the count to zero and clears run (control bit 0).
- R6: With compare on (bit 6), an advance that makes the count equal to the compare value (address 7) is a match event. Match is status bit 0; overflow is status bit 1.
- R7: An event sets its status bit only if the same bit of the interrupt enables (address 2) is set. Writing 1 to a status bit clears it, and a set in the same cycle wins. `irq` is the OR of the status bits.
- R8: On the clock edge of any event enabled in the wakeup mask (address 3), `wake` goes high for exactly one cycle. This does not depend on the interrupt enables.
- R9: A write to address 6 loads the count from the reload value. A write to address 4 sets the count. Either write suppresses counting in that cycle.
- R10: Trigger mode (bits 11:10) is 1 for overflow only and 2 for overflow and match; 0 and 3 mean none. In toggle mode an event inverts `pin_out`. In pulse mode `pin_out` shows the inverse of the idle level for one cycle. While run is 0 or the mode is none, `pin_out` follows the idle level (bit 7).
- R11: `pin_oe` is the inverse of control bit 14.
- R12: A control-word write takes effect from the following clock edge. Events in the write cycle use the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Functional clock enable, one tick per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | CW | Write data |
| reg_rdata | output | CW | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt, OR of the status bits |
| wake | output | 1 | One-cycle wakeup pulse |
| pin_out | output | 1 | Trigger pin level |
| pin_oe | output | 1 | Pin output enable |

## Verification
The hardest situations to reach are coincidences. One is an overflow in the same cycle as a status clear, a count write or a control write. Another is a match that lands exactly on a reload value. Counting up from zero would take billions of cycles before any of these could occur. The stimulus therefore writes count, reload and compare values just below all ones, so that overflows and matches arrive every few cycles. It mixes these with random register writes and random tick gaps, and a per-cycle reference model judges every cycle.

// File: rtl/gp_timer_core.sv
module gp_timer_core #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  output logic          irq,
  output logic          wake,
  output logic          pin_out,
  output logic          pin_oe
);

  localparam logic [2:0] A_CTRL = 3'd0, A_STS = 3'd1, A_IEN = 3'd2, A_WEN = 3'd3,
                         A_CNT = 3'd4, A_REL = 3'd5, A_RETRIG = 3'd6, A_CMP = 3'd7;
  localparam logic [CW-1:0] TOP = '1;

  logic [14:0]   ctrl;
  logic [2:0]    sts, ien, wen;
  logic [CW-1:0] cnt, rel, cmp, nxt;
  logic [7:0]    ps, ps_lim;
  logic          lvl;
  logic          run, ps_hit, cnt_wr, ctrl_wr, adv, ovf, mat, trig_on, trig;
  logic [2:0]    ev, clr;

  assign run     = ctrl[0];
  assign ps_lim  = 8'((9'd2 << ctrl[4:2]) - 9'd1);
  assign ps_hit  = !ctrl[5] || ps == ps_lim;
  assign cnt_wr  = reg_wr && (reg_addr == A_CNT || reg_addr == A_RETRIG);
  assign ctrl_wr = reg_wr && reg_addr == A_CTRL;
  assign adv     = run && tick_en && ps_hit && !cnt_wr;
  assign ovf     = adv && cnt == TOP;
  assign nxt     = ovf ? (ctrl[1] ? rel : '0) : cnt + 1'b1;
  assign mat     = adv && ctrl[6] && nxt == cmp;
  assign ev      = {1'b0, ovf, mat};
  assign clr     = (reg_wr && reg_addr == A_STS) ? reg_wdata[2:0] : 3'b000;
  assign trig_on = ctrl[11:10] == 2'd1 || ctrl[11:10] == 2'd2;
  assign trig    = (trig_on && ovf) || (ctrl[11:10] == 2'd2 && mat);

  assign irq     = |sts;
  assign pin_out = lvl;
  assign pin_oe  = !ctrl[14];

  always_comb begin
    case (reg_addr)
      A_CTRL:   reg_rdata = CW'(ctrl);
      A_STS:    reg_rdata = CW'(sts);
      A_IEN:    reg_rdata = CW'(ien);
      A_WEN:    reg_rdata = CW'(wen);
      A_CNT:    reg_rdata = cnt;
      A_REL:    reg_rdata = rel;
      A_RETRIG: reg_rdata = TOP;
      default:  reg_rdata = cmp;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; sts <= '0; ien <= '0; wen <= '0;
      cnt  <= '0; rel <= '0; cmp <= '0; ps  <= '0;
      lvl  <= 1'b0; wake <= 1'b0;
    end else begin
      sts  <= (sts & ~clr) | (ev & ien);
      wake <= |(ev & wen);

      if (!run || !ctrl[5])  ps <= '0;
      else if (tick_en)      ps <= (ps == ps_lim) ? '0 : ps + 1'b1;

      if (reg_wr && reg_addr == A_CNT)         cnt <= reg_wdata;
      else if (reg_wr && reg_addr == A_RETRIG) cnt <= rel;
      else if (adv)                            cnt <= nxt;

      if (ctrl_wr)                 ctrl <= reg_wdata[14:0];
      else if (ovf && !ctrl[1])    ctrl[0] <= 1'b0;

      if (reg_wr && reg_addr == A_IEN) ien <= reg_wdata[2:0];
      if (reg_wr && reg_addr == A_WEN) wen <= reg_wdata[2:0];
      if (reg_wr && reg_addr == A_REL) rel <= reg_wdata;
      if (reg_wr && reg_addr == A_CMP) cmp <= reg_wdata;

      if (!run || !trig_on)  lvl <= ctrl[7];
      else if (!ctrl[12])    lvl <= trig ? !ctrl[7] : ctrl[7];
      else if (trig)         lvl <= !lvl;
    end
  end

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !ovf |=> cnt == $past(cnt) + 1'b1);
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && ctrl[1] |=> cnt == $past(rel));
  p_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !ctrl[1] && !ctrl_wr |=> cnt == '0 && !ctrl[0]);
  p_ovf_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[1]) |-> $past(ien[1]));
  p_mat_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[0]) |-> $past(ien[0]));
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == A_STS && reg_wdata[1] && !ovf |=> !sts[1]);
  p_wake_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(|wen));
  p_idle_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !ctrl_wr |=> pin_out == $past(ctrl[7]));

endmodule

// File: tb/sim_gp_timer_core.sv
module sim_gp_timer_core;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic irq, wake, pin_out, pin_oe;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gp_timer_core #(.CW(32)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick), .reg_wr(wr), .reg_addr(addr),
    .reg_wdata(wd), .reg_rdata(rdata), .irq(irq), .wake(wake),
    .pin_out(pin_out), .pin_oe(pin_oe));

  logic [14:0] m_ctrl; logic [2:0] m_sts, m_ien, m_wen;
  logic [31:0] m_cnt, m_rel, m_cmp; int m_ps; logic m_lvl, m_wake;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(logic [2:0] a);
    case (a)
      0: return {17'd0, m_ctrl};
      1: return {29'd0, m_sts};
      2: return {29'd0, m_ien};
      3: return {29'd0, m_wen};
      4: return m_cnt;
      5: return m_rel;
      6: return 32'hFFFF_FFFF;
      default: return m_cmp;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_sts = 0; m_ien = 0; m_wen = 0; m_cnt = 0; m_rel = 0;
      m_cmp = 0; m_ps = 0; m_lvl = 0; m_wake = 0;
    end else begin
      int lim; bit run, adv, ovf, mat, trig, tmode_ok; logic [31:0] nx; logic [2:0] ev;
      run = m_ctrl[0];
      lim = (2 << m_ctrl[4:2]) - 1;
      adv = run && tick && (!m_ctrl[5] || m_ps == lim) && !(wr && (addr == 4 || addr == 6));
      ovf = adv && m_cnt == 32'hFFFF_FFFF;
      nx  = ovf ? (m_ctrl[1] ? m_rel : 32'd0) : m_cnt + 1;
      mat = adv && m_ctrl[6] && nx == m_cmp;
      ev  = {1'b0, ovf, mat};
      tmode_ok = m_ctrl[11:10] == 1 || m_ctrl[11:10] == 2;
      trig = (tmode_ok && ovf) || (m_ctrl[11:10] == 2 && mat);
      if (!run || !tmode_ok) m_lvl = m_ctrl[7];
      else if (!m_ctrl[12]) m_lvl = trig ? !m_ctrl[7] : m_ctrl[7];
      else if (trig) m_lvl = !m_lvl;
      m_wake = |(ev & m_wen);
      m_sts = (m_sts & ~((wr && addr == 1) ? wd[2:0] : 3'd0)) | (ev & m_ien);
      if (!run || !m_ctrl[5]) m_ps = 0;
      else if (tick) m_ps = (m_ps == lim) ? 0 : m_ps + 1;
      if (wr && addr == 4) m_cnt = wd;
      else if (wr && addr == 6) m_cnt = m_rel;
      else if (adv) m_cnt = nx;
      if (wr && addr == 0) m_ctrl = wd[14:0];
      else if (ovf && !m_ctrl[1]) m_ctrl[0] = 1'b0;
      if (wr && addr == 2) m_ien = wd[2:0];
      if (wr && addr == 3) m_wen = wd[2:0];
      if (wr && addr == 5) m_rel = wd;
      if (wr && addr == 7) m_cmp = wd;
    end
    #2;
    if (rst_n && !done) begin
      chk(addr == 4 ? "R2 count" : "R7 register", rdata, m_read(addr));
      chk("R7 irq", {31'd0, irq}, {31'd0, |m_sts});
      chk("R8 wake", {31'd0, wake}, {31'd0, m_wake});
      chk("R10 pin", {31'd0, pin_out}, {31'd0, m_lvl});
      chk("R11 oe", {31'd0, pin_oe}, {31'd0, !m_ctrl[14]});
    end
  end

  task automatic wreg(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wr = 1; addr = a; wd = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rreg(logic [2:0] a, output logic [31:0] v);
    addr = a; #1 v = rdata;
  endtask

  task automatic edges(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, a0, a1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 8; a++) begin
      rreg(3'(a), v);
      chk("R1 reset reg", v, a == 6 ? 32'hFFFF_FFFF : 32'd0);
    end
    chk("R1 reset pins", {28'd0, irq, wake, pin_out, pin_oe}, 32'd1);
    tick = 1;

    wreg(4, 0); wreg(0, 1);
    rreg(4, a0); edges(5); rreg(4, a1);
    chk("R2 step five", a1 - a0, 5);
    tick = 0; rreg(4, a0); edges(4); rreg(4, a1);
    chk("R2 no tick hold", a1, a0);
    tick = 1;

    wreg(0, 0); wreg(2, 3); wreg(3, 2); wreg(4, 32'hFFFF_FFFE); wreg(5, 7);
    wreg(0, 3);
    rreg(4, v); chk("R12 ctrl next edge", v, 32'hFFFF_FFFE);
    edges(2);
    rreg(4, v); chk("R4 reload", v, 7);
    rreg(0, v); chk("R4 run kept", {31'd0, v[0]}, 1);
    chk("R7 irq set", {31'd0, irq}, 1);
    chk("R8 wake high", {31'd0, wake}, 1);
    edges(1);
    chk("R8 wake one cycle", {31'd0, wake}, 0);
    rreg(4, v); chk("R4 continue", v, 8);

    wreg(0, 0); wreg(6, 0);
    rreg(4, v); chk("R9 retrigger", v, 7);
    wreg(4, 32'h1234);
    rreg(4, v); chk("R9 count write", v, 32'h1234);
    wreg(1, 7);
    chk("R7 w1c irq low", {31'd0, irq}, 0);

    wreg(4, 32'hFFFF_FFFE); wreg(0, 1); edges(2);
    rreg(4, v); chk("R5 clear", v, 0);
    rreg(0, v); chk("R5 run off", {31'd0, v[0]}, 0);
    rreg(1, v); chk("R6 ovf bit", v, 2);

    wreg(1, 7); wreg(4, 0); wreg(7, 3); wreg(0, 32'h41);
    edges(2); rreg(1, v); chk("R6 no match early", v, 0);
    edges(1); rreg(1, v); chk("R6 match bit", v, 1);
    rreg(4, v); chk("R6 at compare", v, 3);

    wreg(0, 0); wreg(2, 0); wreg(1, 7); wreg(4, 32'hFFFF_FFFE); wreg(0, 1); edges(2);
    chk("R7 masked no irq", {31'd0, irq}, 0);

    wreg(0, 0); wreg(4, 0); wreg(0, 32'h25); edges(8);
    rreg(4, v); chk("R3 prescale", v, 2);

    wreg(0, 0); wreg(4, 32'hFFFF_FFFF); wreg(5, 32'hFFFF_FFFE); wreg(0, 32'h1403);
    edges(1); chk("R10 toggle on", {31'd0, pin_out}, 1);
    edges(1); chk("R10 toggle hold", {31'd0, pin_out}, 1);
    edges(1); chk("R10 toggle off", {31'd0, pin_out}, 0);

    wreg(0, 0); wreg(4, 32'hFFFF_FFFF); wreg(0, 32'h483);
    edges(1); chk("R10 pulse low", {31'd0, pin_out}, 0);
    edges(1); chk("R10 idle level", {31'd0, pin_out}, 1);

    wreg(0, 32'h4000);
    chk("R11 input dir", {31'd0, pin_oe}, 0);

    wreg(2, 3); wreg(3, 3);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      tick = ($urandom % 4) != 0;
      addr = 3'($urandom);
      wr = ($urandom % 6) == 0;
      case (addr)
        0: wd = {17'd0, 15'($urandom) | 15'd1};
        4, 5, 7: wd = 32'hFFFF_FFF0 | 32'($urandom % 16);
        default: wd = $urandom;
      endcase
    end
    @(negedge clk); wr = 0;
    edges(2);
    finish_run();
  end
endmodule